// File: doc/BRIEF.md
# Chip-Enable Gate for Battery-Backed Memory

This block sits between a processor's memory chip-enable line (active low) and a static RAM that must keep its contents through a supply failure. While the system reset flag is low, the chip-enable passes straight through. When the reset flag rises, the block closes the path so that a failing processor cannot write garbage. Once the path is closed, the memory sees only the inactive (high) level.

If a memory access is in flight when reset rises, meaning chip-enable is low, the block does not cut the access short. It holds the path open until chip-enable returns high, or until a fixed drain window of clock cycles has expired, whichever comes first. The block closes the path immediately if chip-enable is already high when reset is seen. When the reset flag falls, the path reopens on the next clock. A two-bit status output reports whether the gate is open, draining or shut.

All decisions are taken on the rising clock edge. The output multiplexer is combinational, so a pass-through adds no cycle of latency.

Top module: `ceg_gate`

## Requirements
- R1: While `rst` is high, the state becomes open. After `rst` falls, `gate_state` reads 2'b00 and `gate_open` reads 1.
- R2: While the state is open, `ce_n_out` equals `ce_n_in` in the same cycle. A clock edge that samples `hold` low leaves or returns the state to open.
- R3: A clock edge that samples `hold` high while the state is open and `ce_n_in` is high moves the state straight to shut.
- R4: A clock edge that samples `hold` high while the state is open and `ce_n_in` is low moves the state to drain. While the state is drain, `ce_n_out` equals `ce_n_in`.
- R5: In drain, a clock edge that samples `ce_n_in` high with `hold` still high moves the state to shut.
- R6: With `hold` high and `ce_n_in` held low, the state stays in drain for exactly `DRAIN_CYCLES` cycles and then becomes shut.
- R7: While the state is shut, `ce_n_out` is 1 whatever `ce_n_in` does. The state stays shut as long as `hold` is sampled high.
- R8: A clock edge that samples `hold` low while the state is drain or shut moves the state to open. A later drain is again granted the full `DRAIN_CYCLES` window.
- R9: `gate_state` uses the encoding open = 2'b00, drain = 2'b01 and shut = 2'b10, and never shows 2'b11. `gate_open` is 1 exactly when the state is not shut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the state machine and the drain timer |
| rst | input | 1 | Synchronous active-high reset of the block's own state |
| hold | input | 1 | System reset flag; high means the memory must be protected |
| ce_n_in | input | 1 | Chip-enable from the processor, active low |
| ce_n_out | output | 1 | Gated chip-enable to the memory, active low |
| gate_open | output | 1 | High while chip-enable can reach the memory |
| gate_state | output | 2 | Current state: 00 open, 01 drain, 10 shut |

## Verification
The bench targets three corner cases. The first is a drain held to its full length: a timer that is off by one would show a drain one cycle too short or too long. The second is a drain ended early by a rising chip-enable: a design that ignored the rising edge would leave the memory selected until the timeout. The third is a reset flag that falls in the middle of a drain and then rises again: a counter that does not clear would grant the second access a truncated window. Random stretches of reset and chip-enable activity are compared every cycle against a bench model. That comparison catches a design that leaks an input transition through while shut, or that reopens late.

// File: rtl/ceg_pkg.sv
package ceg_pkg;

    typedef enum logic [1:0] {
        GS_OPEN  = 2'b00,
        GS_DRAIN = 2'b01,
        GS_SHUT  = 2'b10
    } gate_state_e;

    // Gate path conducts in every state except shut.
    function automatic logic path_conducts(gate_state_e s);
        return (s != GS_SHUT);
    endfunction

    // Counter width for a window of n cycles (at least one bit).
    function automatic int unsigned win_width(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ceg_drain_timer.sv
module ceg_drain_timer
    import ceg_pkg::*;
#(
    parameter int unsigned LIMIT = 1875
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);

    localparam int unsigned     CW   = win_width(LIMIT);
    localparam logic [CW-1:0]   LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // Counts cycles spent draining; cleared whenever the drain is not running.
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == LAST);

    // The state machine must leave drain on the edge the window runs out.
    AST_TMO_ENDS_DRAIN: assert property (@(posedge clk) disable iff (rst)
        expired |=> !run); // R6

endmodule

// File: rtl/ceg_gate_fsm.sv
module ceg_gate_fsm
    import ceg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        hold,
    input  logic        ce_n_in,
    input  logic        expired,
    output gate_state_e state
);

    gate_state_e state_nx;

    always_comb begin
        state_nx = state;
        if (!hold) begin
            state_nx = GS_OPEN;
        end else begin
            unique case (state)
                GS_OPEN:  state_nx = ce_n_in ? GS_SHUT : GS_DRAIN;
                GS_DRAIN: state_nx = (ce_n_in || expired) ? GS_SHUT : GS_DRAIN;
                GS_SHUT:  state_nx = GS_SHUT;
                default:  state_nx = GS_SHUT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= GS_OPEN;
        end else begin
            state <= state_nx;
        end
    end

    AST_RESET_OPEN: assert property (@(posedge clk)
        rst |=> (state == GS_OPEN)); // R1

    AST_IDLE_SHUT: assert property (@(posedge clk) disable iff (rst)
        (state == GS_OPEN && hold && ce_n_in) |=> (state == GS_SHUT)); // R3

    AST_DRAIN_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (state == GS_OPEN && hold && !ce_n_in) |=> (state == GS_DRAIN)); // R4

    AST_DRAIN_END: assert property (@(posedge clk) disable iff (rst)
        (state == GS_DRAIN && hold && ce_n_in) |=> (state == GS_SHUT)); // R5

    AST_SHUT_STAYS: assert property (@(posedge clk) disable iff (rst)
        (state == GS_SHUT && hold) |=> (state == GS_SHUT)); // R7

    AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        !hold |=> (state == GS_OPEN)); // R8

endmodule

// File: rtl/ceg_ce_mux.sv
module ceg_ce_mux
    import ceg_pkg::*;
(
    input  gate_state_e state,
    input  logic        ce_n_in,
    output logic        ce_n_out,
    output logic        gate_open
);

    always_comb begin
        gate_open = path_conducts(state);
        ce_n_out  = gate_open ? ce_n_in : 1'b1;
    end

endmodule

// File: rtl/ceg_gate.sv
module ceg_gate
    import ceg_pkg::*;
#(
    parameter int unsigned DRAIN_CYCLES = 1875
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hold,
    input  logic       ce_n_in,
    output logic       ce_n_out,
    output logic       gate_open,
    output logic [1:0] gate_state
);

    gate_state_e state;
    logic        expired;

    ceg_drain_timer #(.LIMIT(DRAIN_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (state == GS_DRAIN),
        .expired (expired)
    );

    ceg_gate_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .hold    (hold),
        .ce_n_in (ce_n_in),
        .expired (expired),
        .state   (state)
    );

    ceg_ce_mux u_mux (
        .state     (state),
        .ce_n_in   (ce_n_in),
        .ce_n_out  (ce_n_out),
        .gate_open (gate_open)
    );

    assign gate_state = state;

    AST_SHUT_FORCES_HIGH: assert property (@(posedge clk) disable iff (rst)
        (gate_state == 2'b10) |-> ce_n_out); // R7

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (gate_state != 2'b10) |-> (ce_n_out == ce_n_in)); // R2

    AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (rst)
        (gate_state != 2'b11) && (gate_open == (gate_state != 2'b10))); // R9

endmodule

// File: tb/sim_ceg_gate.sv
module sim_ceg_gate;

    localparam int unsigned TMO = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hold = 1'b0;
    logic       ce_n_in = 1'b1;
    logic       ce_n_out;
    logic       gate_open;
    logic [1:0] gate_state;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    // Bench model: 0 open, 1 drain, 2 shut (codes per R9).
    int m_state = 0;
    int m_cnt   = 0;

    always #4 clk = ~clk;

    ceg_gate #(.DRAIN_CYCLES(TMO)) u0 (
        .clk        (clk),
        .rst        (rst),
        .hold       (hold),
        .ce_n_in    (ce_n_in),
        .ce_n_out   (ce_n_out),
        .gate_open  (gate_open),
        .gate_state (gate_state)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not end (actual %0d cycles, expected fewer)", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic expect_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic string tag_of(input int s);
        return (s == 0) ? "R2" : (s == 1) ? "R4" : "R7";
    endfunction

    function automatic int next_state(input int s, input int cnt, input logic h, input logic c);
        if (!h) return 0;
        if (s == 0) return c ? 2 : 1;
        if (s == 1) return (c || cnt == TMO - 1) ? 2 : 1;
        return 2;
    endfunction

    // One cycle: drive at the falling edge, compare just after, update model at the rising edge.
    task automatic step(input logic h, input logic c);
        int ns;
        @(negedge clk);
        hold    = h;
        ce_n_in = c;
        #1;
        expect_eq(tag_of(m_state), int'(gate_state), m_state);
        expect_eq("R9", int'(gate_open), (m_state != 2) ? 1 : 0);
        expect_eq(tag_of(m_state), int'(ce_n_out), (m_state == 2) ? 1 : int'(c));
        @(posedge clk);
        ns      = next_state(m_state, m_cnt, h, c);
        m_cnt   = (ns == 1 && m_state == 1) ? m_cnt + 1 : 0;
        m_state = ns;
    endtask

    task automatic observe(output int st);
        @(negedge clk);
        #1;
        st = int'(gate_state);
    endtask

    initial begin
        int drain_len;
        int st;
        void'($urandom(32'd20240611));

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        expect_eq("R1", int'(gate_state), 0);
        expect_eq("R1", int'(gate_open), 1);
        expect_eq("R1", int'(ce_n_out), int'(ce_n_in));

        // R2: transparent pass-through
        step(0, 0); step(0, 1); step(0, 0); step(0, 1);

        // R3: reset flag with chip-enable idle shuts at once; R7: input ignored
        step(1, 1);
        step(1, 0);
        expect_eq("R3", int'(gate_state), 2);
        expect_eq("R7", int'(ce_n_out), 1);
        step(1, 1); step(1, 0);

        // R8: release reopens on the next clock
        step(0, 0);
        observe(st);
        expect_eq("R8", st, 0);

        // R4 then R5: access in flight, ended by rising chip-enable
        step(0, 1);
        step(1, 0);
        step(1, 0);
        expect_eq("R4", int'(gate_state), 1);
        expect_eq("R4", int'(ce_n_out), 0);
        step(1, 0);
        step(1, 1);
        step(1, 0);
        expect_eq("R5", int'(gate_state), 2);
        expect_eq("R5", int'(ce_n_out), 1);

        // R6: full-length drain
        step(0, 1);
        step(1, 0);
        drain_len = 0;
        for (int i = 0; i < TMO + 3; i++) begin
            step(1, 0);
            if (gate_state == 2'b01) drain_len++;
        end
        expect_eq("R6", drain_len, TMO);
        expect_eq("R6", int'(gate_state), 2);

        // R8: release mid-drain, then a new drain gets the full window
        step(0, 1);
        step(1, 0);
        for (int i = 0; i < 5; i++) step(1, 0);
        step(0, 0);
        step(1, 0);
        drain_len = 0;
        for (int i = 0; i < TMO + 3; i++) begin
            step(1, 0);
            if (gate_state == 2'b01) drain_len++;
        end
        expect_eq("R8", drain_len, TMO);

        // Random stretches of reset and chip-enable activity
        for (int i = 0; i < 4000; i++) begin
            logic h;
            logic c;
            h = (($urandom % 8) < 5);
            c = (($urandom % 4) != 0) ? ce_n_in : ~ce_n_in;
            step(h, c);
        end

        // R1: synchronous reset while shut returns to open
        step(1, 1);
        step(1, 1);
        @(negedge clk);
        rst = 1'b1;
        hold = 1'b1;
        @(posedge clk);
        @(negedge clk);
        #1;
        expect_eq("R1", int'(gate_state), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule